// File: doc/BRIEF.md
# Extended Precision Floating Point Divider

This block divides one 48-bit extended precision floating point number by another. Each number has a signed 8-bit exponent and a 40-bit two's-complement fractional mantissa. The mantissa bit pattern M stands for M/2^39, so the number is worth (M/2^39)·2^E. A value travels as three 16-bit words. The divider takes the dividend and divisor through a valid/ready input handshake. It returns the quotient in the same three-word layout through a valid/ready output handshake. With the quotient come an overflow flag, an underflow flag and a 4-bit condition code.

The exponent difference is worked out when the operands are accepted. A zero divisor, or an exponent difference that already cannot be represented, ends the operation at once with a saturated or zeroed result. Otherwise the mantissa magnitudes go through a one-bit-per-cycle restoring division. The quotient is brought back below 1.0 by a single right shift, and its sign is restored. Saturation applies a second time if the adjusted exponent is out of range.

Back-pressure: a finished result is held with `out_valid` high and every output stable until `out_ready` is seen high on a clock edge. The input side is closed (`in_ready` low) from acceptance until that edge. Operand contract: any nonzero mantissa is normalized (magnitude from 0.5 up to 1.0), and the dividend magnitude is below twice the divisor magnitude.

Top module: `xfd_divider`

## Requirements
- R1: Word layout for operands and quotient: word 0 holds mantissa bits 39..24 (the sign at word 0 bit 15), word 1 holds mantissa bits 23..16 in bits 15..8 and the two's-complement exponent in bits 7..0, and word 2 holds mantissa bits 15..0.
- R2: `in_ready` is high only while no operation is in progress and no result is held. Operands are taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` and `out_valid` are never high together.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, the quotient words, the flags and the condition code stay unchanged. After the edge that sees `out_ready` high, `out_valid` is low and `in_ready` is high.
- R4: On an early exit (zero divisor, pre-division overflow or underflow), `out_valid` is high in the cycle right after the accepting edge. Otherwise it rises on the 41st clock edge after the accepting edge.
- R5: For contract operands with a nonzero dividend, the quotient mantissa is the exact ratio, scaled by the applied exponent, truncated toward zero. It is within one LSB of the exact value.
- R6: The quotient exponent is the dividend exponent minus the divisor exponent, plus one when the mantissa ratio magnitude is 1.0 or more. Differences from -128 up to 126 are valid before that adjustment.
- R7: A zero dividend with a nonzero divisor gives an all-zero quotient with both flags low, whatever the exponents are.
- R8: A zero divisor raises the overflow flag and gives exponent 0x7F. The mantissa is 0x7FFFFFFFFF when the operand sign bits are equal and 0x8000000000 when they differ.
- R9: A nonzero dividend whose exponent difference is 127 or more gives the same saturated result and overflow flag as R8.
- R10: A nonzero dividend whose exponent difference is below -128 raises the underflow flag and gives an all-zero quotient.
- R11: If the exponent reaches 127 after the R6 adjustment, the overflow flag is raised and the result saturates as in R8, following the quotient sign.
- R12: The condition code is 0010 for an all-zero quotient, 0001 when the mantissa sign bit is 1, and 0100 otherwise. Both flags are low for results not covered by R8 to R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Divider can take operands |
| dvd_w0 | input | 16 | Dividend word 0 |
| dvd_w1 | input | 16 | Dividend word 1 |
| dvd_w2 | input | 16 | Dividend word 2 |
| dvs_w0 | input | 16 | Divisor word 0 |
| dvs_w1 | input | 16 | Divisor word 1 |
| dvs_w2 | input | 16 | Divisor word 2 |
| out_valid | output | 1 | Quotient available |
| out_ready | input | 1 | Consumer takes the quotient |
| quo_w0 | output | 16 | Quotient word 0 |
| quo_w1 | output | 16 | Quotient word 1 |
| quo_w2 | output | 16 | Quotient word 2 |
| ovf_flag | output | 1 | Overflow (saturated result) |
| unf_flag | output | 1 | Underflow (zero result) |
| cond_code | output | 4 | Zero / negative / positive code |

## Verification
The divide path is driven with all four sign combinations. Ratios fall on both sides of 1.0, which separates the shifted and unshifted normalisation paths. The set includes exact halves, thirds and a near-2 ratio, so truncation toward zero and the one-LSB bound are checked against a real-number model. Exponent differences of 120, 126, 127, -128 and -129 tell the valid range apart from early overflow and from underflow. The 126-with-ratio-above-one case separates late overflow from early overflow. Zero dividend, zero divisor, the two together, and a held result under back-pressure cover the special exits and the handshake.

// File: rtl/xfd_pkg.sv
package xfd_pkg;
  localparam int MANT_W = 40;
  localparam int EXP_W  = 8;
  localparam int WORD_W = 16;
  localparam int WEXP_W = EXP_W + 2;
  localparam int CC_W   = 4;

  typedef logic [WORD_W-1:0]        word_t;
  typedef logic signed [EXP_W-1:0]  exp_t;
  typedef logic [MANT_W-1:0]        mant_t;
  typedef logic signed [WEXP_W-1:0] wexp_t;
  typedef logic [CC_W-1:0]          cc_t;

  typedef struct packed {
    exp_t  e;
    mant_t m;
  } xfloat_t;

  localparam wexp_t WEXP_MAX = wexp_t'(2**(EXP_W-1) - 1);
  localparam wexp_t WEXP_MIN = wexp_t'(-(2**(EXP_W-1)));
  localparam exp_t  EXP_SAT  = exp_t'(2**(EXP_W-1) - 1);
  localparam mant_t SAT_POS  = {1'b0, {(MANT_W-1){1'b1}}};
  localparam mant_t SAT_NEG  = {1'b1, {(MANT_W-1){1'b0}}};

  localparam cc_t CC_ZERO = 4'b0010;
  localparam cc_t CC_NEG  = 4'b0001;
  localparam cc_t CC_POS  = 4'b0100;

  // R1: three-word layout, exponent in the low byte of the middle word
  function automatic xfloat_t unpack_words(word_t w0, word_t w1, word_t w2);
    xfloat_t x;
    x.m = {w0, w1[WORD_W-1:EXP_W], w2};
    x.e = w1[EXP_W-1:0];
    return x;
  endfunction

  function automatic logic [3*WORD_W-1:0] pack_words(xfloat_t x);
    return {x.m[MANT_W-1 -: WORD_W],
            x.m[MANT_W-WORD_W-1 -: (WORD_W-EXP_W)],
            x.e,
            x.m[WORD_W-1:0]};
  endfunction

  function automatic cc_t cond_of(xfloat_t x);
    if (x == '0)             return CC_ZERO;
    else if (x.m[MANT_W-1])  return CC_NEG;
    else                     return CC_POS;
  endfunction
endpackage

// File: rtl/xfd_prescale.sv
module xfd_prescale
  import xfd_pkg::*;
(
  input  xfloat_t dvd,
  input  xfloat_t dvs,
  output wexp_t   n_o,
  output logic    early_ovf_o,
  output logic    early_unf_o,
  output logic    sign_diff_o,
  output mant_t   mag_dvd_o,
  output mant_t   mag_dvs_o
);
  wexp_t n_raw;
  logic  dvd_zero, dvs_zero;

  always_comb begin
    dvd_zero    = (dvd.m == '0);
    dvs_zero    = (dvs.m == '0);
    n_raw       = wexp_t'(dvd.e) - wexp_t'(dvs.e);
    n_o         = dvd_zero ? '0 : n_raw;                 // R7
    early_ovf_o = dvs_zero || (n_o >= WEXP_MAX);         // R8, R9
    early_unf_o = !early_ovf_o && (n_o < WEXP_MIN);      // R10
    sign_diff_o = dvd.m[MANT_W-1] ^ dvs.m[MANT_W-1];
    mag_dvd_o   = dvd.m[MANT_W-1] ? (~dvd.m + mant_t'(1)) : dvd.m;
    mag_dvs_o   = dvs.m[MANT_W-1] ? (~dvs.m + mant_t'(1)) : dvs.m;
  end
endmodule

// File: rtl/xfd_mag_div.sv
module xfd_mag_div #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CNT_W = $clog2(W);
  localparam int REM_W = W + 2;

  logic [REM_W-1:0] rem;
  logic [REM_W-1:0] diff;
  logic [CNT_W-1:0] cnt;
  logic             borrow;

  always_comb begin
    diff   = rem - {2'b00, den};
    borrow = diff[REM_W-1];
  end

  // one restoring step per cycle, first step weighs 2^0
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= {2'b00, num};
        quo  <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        rem <= (borrow ? rem : diff) << 1;
        quo <= {quo[W-2:0], ~borrow};
        if (cnt == CNT_W'(W-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
endmodule

// File: rtl/xfd_postnorm.sv
module xfd_postnorm
  import xfd_pkg::*;
(
  input  mant_t q,
  input  wexp_t n,
  input  logic  sign_diff,
  output exp_t  e_o,
  output mant_t m_o,
  output logic  ovf_o
);
  mant_t qs, mq;
  wexp_t n1;

  always_comb begin
    // R6: magnitude 1.0 or more -> one position right, exponent up
    qs    = q[MANT_W-1] ? (q >> 1) : q;
    n1    = n + (q[MANT_W-1] ? wexp_t'(1) : wexp_t'(0));
    mq    = sign_diff ? (~qs + mant_t'(1)) : qs;
    ovf_o = (n1 >= WEXP_MAX);                               // R11
    m_o   = ovf_o ? (mq[MANT_W-1] ? SAT_NEG : SAT_POS) : mq;
    e_o   = ovf_o ? EXP_SAT : n1[EXP_W-1:0];
  end
endmodule

// File: rtl/xfd_divider.sv
module xfd_divider
  import xfd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] dvd_w0,
  input  logic [15:0] dvd_w1,
  input  logic [15:0] dvd_w2,
  input  logic [15:0] dvs_w0,
  input  logic [15:0] dvs_w1,
  input  logic [15:0] dvs_w2,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] quo_w0,
  output logic [15:0] quo_w1,
  output logic [15:0] quo_w2,
  output logic        ovf_flag,
  output logic        unf_flag,
  output logic [3:0]  cond_code
);
  typedef enum logic [1:0] {S_IDLE, S_DIV, S_DONE} state_t;

  state_t  state;
  xfloat_t dvd, dvs, res_q;
  wexp_t   n_pre, n_q;
  logic    e_ovf, e_unf, sdiff, sdiff_q;
  mant_t   mag_a, mag_b, div_q, pn_m;
  exp_t    pn_e;
  logic    pn_ovf, div_busy, div_done, accept, div_start;
  logic    ovf_q, unf_q;

  assign dvd = unpack_words(dvd_w0, dvd_w1, dvd_w2);
  assign dvs = unpack_words(dvs_w0, dvs_w1, dvs_w2);

  xfd_prescale u_pre (
    .dvd(dvd), .dvs(dvs), .n_o(n_pre), .early_ovf_o(e_ovf),
    .early_unf_o(e_unf), .sign_diff_o(sdiff),
    .mag_dvd_o(mag_a), .mag_dvs_o(mag_b)
  );

  assign in_ready  = (state == S_IDLE);
  assign accept    = in_valid && in_ready;
  assign div_start = accept && !e_ovf && !e_unf;

  xfd_mag_div #(.W(MANT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(mag_a), .den(mag_b),
    .busy(div_busy), .done(div_done), .quo(div_q)
  );

  xfd_postnorm u_post (
    .q(div_q), .n(n_q), .sign_diff(sdiff_q),
    .e_o(pn_e), .m_o(pn_m), .ovf_o(pn_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      res_q   <= '0;
      n_q     <= '0;
      sdiff_q <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          n_q     <= n_pre;
          sdiff_q <= sdiff;
          if (e_ovf) begin
            res_q.e <= EXP_SAT;
            res_q.m <= sdiff ? SAT_NEG : SAT_POS;
            ovf_q   <= 1'b1;
            unf_q   <= 1'b0;
            state   <= S_DONE;
          end else if (e_unf) begin
            res_q   <= '0;
            ovf_q   <= 1'b0;
            unf_q   <= 1'b1;
            state   <= S_DONE;
          end else begin
            state   <= S_DIV;
          end
        end
        S_DIV: if (div_done) begin
          res_q.e <= pn_e;
          res_q.m <= pn_m;
          ovf_q   <= pn_ovf;
          unf_q   <= 1'b0;
          state   <= S_DONE;
        end
        S_DONE: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign out_valid              = (state == S_DONE);
  assign {quo_w0, quo_w1, quo_w2} = pack_words(res_q);
  assign ovf_flag               = ovf_q;
  assign unf_flag               = unf_q;
  assign cond_code              = cond_of(res_q);

  a_r2_ready_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  a_r2_div_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready);
  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(quo_w0) && $stable(quo_w1)
      && $stable(quo_w2) && $stable(ovf_flag) && $stable(unf_flag));
  a_r8_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && ovf_flag |-> quo_w1[7:0] == 8'h7F
      && (quo_w0 == 16'h7FFF || quo_w0 == 16'h8000));
  a_r10_unf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && unf_flag |-> !ovf_flag && quo_w0 == '0 && quo_w1 == '0
      && quo_w2 == '0);
  a_r12_cc_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(cond_code) == 1);
endmodule

// File: tb/xfd_divider_tb_top.sv
module xfd_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [15:0] dvd_w0 = '0, dvd_w1 = '0, dvd_w2 = '0;
  logic [15:0] dvs_w0 = '0, dvs_w1 = '0, dvs_w2 = '0;
  logic        in_ready, out_valid, ovf_flag, unf_flag;
  logic [15:0] quo_w0, quo_w1, quo_w2;
  logic [3:0]  cond_code;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  xfd_divider dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dvd_w0(dvd_w0), .dvd_w1(dvd_w1), .dvd_w2(dvd_w2),
    .dvs_w0(dvs_w0), .dvs_w1(dvs_w1), .dvs_w2(dvs_w2),
    .out_valid(out_valid), .out_ready(out_ready),
    .quo_w0(quo_w0), .quo_w1(quo_w1), .quo_w2(quo_w2),
    .ovf_flag(ovf_flag), .unf_flag(unf_flag), .cond_code(cond_code)
  );

  // {dvd exp, dvd mant, dvs exp, dvs mant, expected exp, {ovf,unf}}
  typedef logic [105:0] vec_t;
  localparam int NV = 21;
  localparam vec_t VEC [0:NV-1] = '{
    {8'h03, 40'h6000000000, 8'h01, 40'h4000000000, 8'h03, 2'b00},
    {8'h00, 40'h4000000000, 8'h00, 40'h6000000000, 8'h00, 2'b00},
    {8'h05, 40'hA000000000, 8'h02, 40'h4000000000, 8'h04, 2'b00},
    {8'hFC, 40'h4CCCCCCCCD, 8'h02, 40'h8CCCCCCCCD, 8'hFA, 2'b00},
    {8'h0A, 40'hC000000000, 8'hFD, 40'hA000000000, 8'h0D, 2'b00},
    {8'h00, 40'h7FFFFFFFFF, 8'h00, 40'h4000000000, 8'h01, 2'b00},
    {8'h00, 40'h8000000000, 8'h00, 40'h6000000000, 8'h01, 2'b00},
    {8'h01, 40'h7333333333, 8'h01, 40'h4CCCCCCCCD, 8'h01, 2'b00},
    {8'h64, 40'h4000000000, 8'hEC, 40'h6000000000, 8'h78, 2'b00},
    {8'h9C, 40'h4000000000, 8'h1C, 40'h6000000000, 8'h80, 2'b00},
    {8'h9C, 40'h4000000000, 8'h1D, 40'h6000000000, 8'h00, 2'b01},
    {8'h64, 40'h4000000000, 8'hE5, 40'h6000000000, 8'h7F, 2'b10},
    {8'h64, 40'hC000000000, 8'hE6, 40'h6000000000, 8'h7E, 2'b00},
    {8'h64, 40'h6000000000, 8'hE6, 40'h4000000000, 8'h7F, 2'b10},
    {8'h64, 40'hA000000000, 8'hE6, 40'h4000000000, 8'h7F, 2'b10},
    {8'h03, 40'h4000000000, 8'h00, 40'h0000000000, 8'h7F, 2'b10},
    {8'h03, 40'hC000000000, 8'h00, 40'h0000000000, 8'h7F, 2'b10},
    {8'h70, 40'h0000000000, 8'h90, 40'h4000000000, 8'h00, 2'b00},
    {8'h00, 40'h0000000000, 8'h00, 40'h0000000000, 8'h7F, 2'b10},
    {8'h80, 40'h4000000000, 8'h01, 40'h4000000000, 8'h00, 2'b01},
    {8'h7F, 40'h4000000000, 8'h81, 40'h4000000000, 8'h7F, 2'b10}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] ea, input logic [39:0] ma,
                       input logic [7:0] eb, input logic [39:0] mb);
    @(negedge clk);
    {dvd_w0, dvd_w1, dvd_w2} = {ma[39:24], ma[23:16], ea, ma[15:0]};
    {dvs_w0, dvs_w1, dvs_w2} = {mb[39:24], mb[23:16], eb, mb[15:0]};
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(posedge clk);
      #1 lat++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R4: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R2", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check(in_ready == 1'b1, "R2", "idle in_ready", in_ready, 1);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] ea, eb, xe;
      logic [39:0] ma, mb, xm;
      logic [1:0] xf;
      int n, lat, xlat, sh;
      bit early, sdiff;
      real r, xmr, dm;
      string rq;
      logic [3:0] xcc;
      {ea, ma, eb, mb, xe, xf} = VEC[i];
      n = int'($signed(ea)) - int'($signed(eb));
      if (ma == '0) n = 0;
      early = (mb == '0) || (n >= 127) || (n < -128);
      sdiff = ma[39] ^ mb[39];
      xlat  = early ? 0 : 41;
      if (mb == '0) rq = "R8";
      else if (ma == '0) rq = "R7";
      else if (n >= 127) rq = "R9";
      else if (n < -128) rq = "R10";
      else if (xf[1]) rq = "R11";
      else rq = "R6";
      drive(ea, ma, eb, mb);
      if (!early)
        check(in_ready == 1'b0, "R2", "busy in_ready", in_ready, 0);
      wait_out(lat);
      check(lat == xlat, "R4", $sformatf("latency v%0d", i), lat, xlat);
      check(quo_w1[7:0] == xe, rq, $sformatf("exponent v%0d", i), quo_w1[7:0], xe);
      check({ovf_flag, unf_flag} == xf, rq, $sformatf("flags v%0d", i),
            {ovf_flag, unf_flag}, xf);
      dm = real'(longint'($signed({quo_w0, quo_w1[15:8], quo_w2})));
      if (xf[1]) xm = sdiff ? 40'h8000000000 : 40'h7FFFFFFFFF;
      else if (xf[0]) xm = '0;
      else begin
        r   = real'(longint'($signed(ma))) / real'(longint'($signed(mb)));
        sh  = n - int'($signed(xe));
        xmr = r * (2.0 ** sh) * 549755813888.0;
        xm  = 40'(longint'(xmr));
      end
      if (xf == 2'b00)
        check((dm - xmr <= 1.0) && (xmr - dm <= 1.0), "R5",
              $sformatf("mantissa v%0d", i), longint'(dm), longint'(xmr));
      else
        check({quo_w0, quo_w1[15:8], quo_w2} == xm, rq,
              $sformatf("mantissa v%0d", i), {quo_w0, quo_w1[15:8], quo_w2}, xm);
      if (xf[1]) xcc = sdiff ? 4'b0001 : 4'b0100;
      else if (xf[0] || ma == '0) xcc = 4'b0010;
      else xcc = sdiff ? 4'b0001 : 4'b0100;
      check(cond_code == xcc, "R12", $sformatf("cond v%0d", i), cond_code, xcc);
      @(posedge clk); #1;
    end

    // R1 word layout of 0.75 * 2^3 and R3 back-pressure
    out_ready = 1'b0;
    begin
      int lat;
      logic [47:0] held;
      drive(8'h03, 40'h6000000000, 8'h01, 40'h4000000000);
      wait_out(lat);
      held = {quo_w0, quo_w1, quo_w2};
      check(held == 48'h6000_0003_0000, "R1", "packed words", held, 48'h600000030000);
      for (int k = 0; k < 5; k++) begin
        @(posedge clk); #1;
        check(out_valid && !in_ready && {quo_w0, quo_w1, quo_w2} == held,
              "R3", "held under back-pressure",
              {out_valid, in_ready, quo_w0, quo_w1, quo_w2}, {2'b10, held});
      end
      @(negedge clk) out_ready = 1'b1;
      @(posedge clk); #1;
      check(!out_valid && in_ready, "R3", "release", {out_valid, in_ready}, 2'b01);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule